// File: doc/BRIEF.md
# LIN Header Margin Encoder

This block runs on the slave side of a LIN link. It times each incoming header and reports how much time is left before the longest header the link allows. A counter is clocked by a sampling tick that comes sixteen times per bit. The counter starts on the falling edge that opens the break and stops when the header-received pulse arrives. The block subtracts the measured time from the 57-bit limit, rounds the result to the nearest quarter bit and stores it in an 8-bit read-only value. The upper six bits hold whole bit times and the lower two bits hold quarters.

Two events overwrite the stored value with fixed codes. A detected break writes FFh and a header timeout writes 00h. Software sees the value on a shared read path only when the node is a slave and at least one of the two header-related enables is set. In every other case a read returns zero.

Top module: `lin_hdr_margin`

## Requirements
- R1: After reset the stored value is 00h.
- R2: A break-detected pulse, with no timeout in the same cycle, makes the stored value FFh on the next clock edge.
- R3: A timeout pulse makes the stored value 00h on the next clock edge.
- R4: A header-received pulse, with no break and no timeout in the same cycle, stores round(4·(57 − T)) on the next edge. T is the header time in bits, equal to the count of ticks that arrived between the break-start pulse and the header pulse, divided by 16. Bits [7:2] hold the whole bits and bits [1:0] hold quarters (0 = .00, 1 = .25, 2 = .50, 3 = .75). A fraction of exactly one eighth rounds up.
- R5: When rounding reaches a full bit, the quarter field becomes 0 and the whole-bit field is incremented. For example, a margin of 911/16 bits encodes as E4h.
- R6: A header of 57 bits or longer encodes as 00h. An encoded margin never exceeds FCh.
- R7: When several events fall in the same cycle, timeout wins over break, and break wins over header-received.
- R8: The tick counter resets on the break-start pulse. It counts only until a header or timeout pulse arrives, and it saturates at its maximum instead of wrapping.
- R9: The read data equals the stored value only when the read strobe is high, slave mode is set, and either the auto-sync enable or the header-detect enable is set. Otherwise the read data is 00h.
- R10: With no break, timeout or header pulse, the stored value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sampling tick, 16 per bit time |
| brk_fall | input | 1 | Pulse on the falling edge that opens the break |
| brk_det | input | 1 | Break-detected pulse |
| hdr_ok | input | 1 | Header successfully received |
| hdr_tmo | input | 1 | Header time limit exceeded |
| slave | input | 1 | Node is in slave mode |
| auto_sync_en | input | 1 | Automatic resynchronisation enable |
| hdr_det_en | input | 1 | Header detection mode enable |
| rd_stb | input | 1 | Read strobe for the value |
| rd_data | output | 8 | Gated read data |

## Verification
Timeout, break and header-received can all pulse in the same clock cycle. The bench first loads a known encoded value with a real header. It then drives each pair of these pulses, and then all three, in one cycle, and reads the value back through the gated read path. The expected code follows the fixed order: timeout gives 00h, break alone gives FFh, and the header code appears only when it arrives alone. Each pair is preceded by a load that differs from the expected code, so a wrong winner shows up.

// File: rtl/lin_hdr_margin.sv
module lin_hdr_margin #(
  parameter int TICKS_PER_BIT = 16,
  parameter int LIMIT_BITS    = 57
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       brk_fall,
  input  logic       brk_det,
  input  logic       hdr_ok,
  input  logic       hdr_tmo,
  input  logic       slave,
  input  logic       auto_sync_en,
  input  logic       hdr_det_en,
  input  logic       rd_stb,
  output logic [7:0] rd_data
);
  localparam int LIMIT_TICKS = LIMIT_BITS * TICKS_PER_BIT;
  localparam int CNT_W       = $clog2(2 * LIMIT_TICKS);
  localparam int SH          = $clog2(TICKS_PER_BIT) - 2;
  localparam int RND         = 1 << (SH - 1);
  localparam logic [CNT_W:0]   LIM_R   = (LIMIT_TICKS + RND);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;
  logic             running;
  logic [7:0]       hdr_len;
  logic [CNT_W:0]   diff, quarters;
  logic [7:0]       code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (brk_fall) begin
      count   <= '0;
      running <= 1'b1;
    end else begin
      if (hdr_ok || hdr_tmo) running <= 1'b0;
      if (running && tick && count != CNT_MAX) count <= count + 1'b1;
    end
  end

  assign diff     = ({1'b0, count} >= LIM_R) ? '0 : LIM_R - {1'b0, count};
  assign quarters = diff >> SH;
  assign code     = (quarters > (CNT_W+1)'(252)) ? 8'hFC : quarters[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hdr_len <= 8'h00;
    else if (hdr_tmo) hdr_len <= 8'h00;
    else if (brk_det) hdr_len <= 8'hFF;
    else if (hdr_ok)  hdr_len <= code;
  end

  assign rd_data = (rd_stb && slave && (auto_sync_en || hdr_det_en)) ? hdr_len : 8'h00;
endmodule

module lin_hdr_margin_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk_fall,
  input logic             brk_det,
  input logic             hdr_ok,
  input logic             hdr_tmo,
  input logic             slave,
  input logic             auto_sync_en,
  input logic             hdr_det_en,
  input logic             rd_stb,
  input logic [7:0]       rd_data,
  input logic [7:0]       hdr_len,
  input logic [CNT_W-1:0] count,
  input logic             running
);
  a_r2_break_code: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && !hdr_tmo) |=> hdr_len == 8'hFF);
  a_r3_timeout_code: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_tmo |=> hdr_len == 8'h00);
  a_r6_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_len <= 8'hFC) || (hdr_len == 8'hFF));
  a_r8_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !brk_fall) |=> $stable(count));
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1 && !brk_fall) |=> count == '1);
  a_r9_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && slave && (auto_sync_en || hdr_det_en)) |-> rd_data == 8'h00);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_det || hdr_tmo || hdr_ok) |=> $stable(hdr_len));
endmodule

bind lin_hdr_margin lin_hdr_margin_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_fall(brk_fall), .brk_det(brk_det),
  .hdr_ok(hdr_ok), .hdr_tmo(hdr_tmo), .slave(slave),
  .auto_sync_en(auto_sync_en), .hdr_det_en(hdr_det_en), .rd_stb(rd_stb),
  .rd_data(rd_data), .hdr_len(hdr_len), .count(count), .running(running)
);

// File: tb/lin_hdr_margin_tb.sv
module lin_hdr_margin_tb;
  logic clk = 0, rst_n = 0;
  logic tick = 0, brk_fall = 0, brk_det = 0, hdr_ok = 0, hdr_tmo = 0;
  logic slave = 1, auto_sync_en = 1, hdr_det_en = 0, rd_stb = 0;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lin_hdr_margin u_dut (.*);

  function automatic logic [7:0] expect_code(int n);
    int m = 912 - n;
    int q;
    if (m < 0) return 8'h00;
    q = (m + 2) / 4;
    if (q > 252) q = 252;
    return q[7:0];
  endfunction

  task automatic check(string req, logic [7:0] exp);
    logic [7:0] got;
    @(negedge clk);
    rd_stb = 1;
    #1 got = rd_data;
    rd_stb = 0;
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic header(int n);
    @(negedge clk); brk_fall = 1;
    @(negedge clk); brk_fall = 0; tick = 1;
    repeat (n) @(negedge clk);
    tick = 0; hdr_ok = 1;
    @(negedge clk); hdr_ok = 0;
  endtask

  task automatic pulse(logic t, logic b, logic h);
    @(negedge clk); hdr_tmo = t; brk_det = b; hdr_ok = h;
    @(negedge clk); hdr_tmo = 0; brk_det = 0; hdr_ok = 0;
  endtask

  initial begin
    #3000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset", 8'h00);

    for (int n = 0; n <= 1000; n += 7) begin
      header(n);
      check("R4 sweep", expect_code(n));
    end
    header(1);   check("R5 carry", 8'hE4);
    header(6);   check("R4 half-quarter up", 8'hE3);
    header(912); check("R6 at limit", 8'h00);
    header(2100); check("R8 saturate", 8'h00);

    pulse(0, 1, 0); check("R2 break", 8'hFF);
    pulse(1, 0, 0); check("R3 timeout", 8'h00);
    pulse(0, 1, 0);
    repeat (20) @(negedge clk);
    check("R10 hold", 8'hFF);

    header(100);   pulse(1, 1, 0); check("R7 tmo over brk", 8'h00);
    header(100);   pulse(1, 0, 1); check("R7 tmo over hdr", 8'h00);
    header(100);   pulse(0, 1, 1); check("R7 brk over hdr", 8'hFF);
    pulse(0, 1, 0); pulse(1, 1, 1); check("R7 all three", 8'h00);

    header(100);
    slave = 0; check("R9 not slave", 8'h00);
    slave = 1; auto_sync_en = 0; hdr_det_en = 0; check("R9 no enable", 8'h00);
    hdr_det_en = 1; check("R9 hdr-detect only", expect_code(100));
    hdr_det_en = 0; auto_sync_en = 1; check("R9 auto-sync only", expect_code(100));
    @(negedge clk); #1; n_chk++;
    if (rd_data !== 8'h00) begin
      n_bad++;
      $display("FAIL R9 no strobe: got %02h expected 00", rd_data);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule